// File: doc/BRIEF.md
# Double-Precision Funnel Right Shifter

This execution unit shifts a destination operand to the right. The high-order bit positions that the shift empties are filled from the low bits of a second, fill-source operand. Chaining such operations gives shifts of 64 bits or more. The unit handles 16-bit and 32-bit operand sizes. The shift count arrives as an 8-bit value, and the unit uses only its low 5 bits.

The unit has a single register stage. On a cycle with `in_valid_i` high it takes the destination, the fill source, the count, the size select and the incoming flags. On the next cycle it presents the new destination value, the carry, sign, zero and parity flags, and an update-enable for each flag. The unit only reads the fill source; it never returns that operand.

A zero effective count leaves the destination and all flags untouched, and all flag enables stay low. In 16-bit mode, an effective count of 16 to 31 gives an unspecified low result and unspecified flags. The upper half of the destination still passes through unchanged. Auxiliary-carry and overflow are not driven, and the consumer may treat them as undefined.

Top module: `fshr_unit`

## Requirements
- R1: `out_valid_o` is high in the cycle after a cycle in which `in_valid_i` is high, and low otherwise. Reset clears `out_valid_o`, `flags_we_o` and `res_o`.
- R2: The effective amount N is `cnt_i` modulo 32, which is its low 5 bits. Counts that differ only in bits 7:5 give identical outputs in both sizes.
- R3: When N is 0, `res_o` equals the destination input and `flags_o` equals `flags_i`, with `flags_we_o` at 0.
- R4: In 32-bit mode (`wide_i`=1), for 1 ≤ N ≤ 31, result bit i is destination bit i+N for i < 32−N. Result bit i is source bit i+N−32 for i ≥ 32−N.
- R5: In 16-bit mode (`wide_i`=0), for 1 ≤ N ≤ 15, result bit i is destination bit i+N for i < 16−N. Result bit i is source bit i+N−16 for 16−N ≤ i ≤ 15. `res_o[31:16]` always equals destination bits 31:16.
- R6: For a valid nonzero N, the carry (`flags_o[3]`) is destination bit N−1.
- R7: For a valid nonzero N, the sign (`flags_o[2]`) is result bit 31 in 32-bit mode and result bit 15 in 16-bit mode.
- R8: For a valid nonzero N, the zero flag (`flags_o[1]`) is 1 exactly when all active result bits are 0.
- R9: For a valid nonzero N, parity (`flags_o[0]`) is 1 when `res_o[7:0]` holds an even number of ones.
- R10: For a nonzero N, `flags_we_o` is 4'b1111, with one enable bit per `flags_o` bit. In 16-bit mode with N from 16 to 31, the only defined outputs are the upper-half pass-through and `out_valid_o`.
- R11: In a cycle with `in_valid_i` low, `res_o` keeps its value on the next cycle and `flags_we_o` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operation request |
| wide_i | input | 1 | 1 = 32-bit operands, 0 = 16-bit |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Fill-source operand (read only) |
| cnt_i | input | 8 | Shift count |
| flags_i | input | 4 | Incoming {carry, sign, zero, parity} |
| out_valid_o | output | 1 | Result valid |
| res_o | output | 32 | New destination value |
| flags_o | output | 4 | {carry, sign, zero, parity} |
| flags_we_o | output | 4 | Update-enable per flag bit |

## Verification
The bench uses the default parameters: a 32-bit data path and an 8-bit count. With these defaults, every count from 0 to 255 can be driven in both operand sizes. This exercises the modulo-32 wrap, the zero-count hold and the 16-bit out-of-range band of 16 to 31 against a bitwise reference model. Directed corner operands check the carry edge at N=1 and at the top valid amount. Further directed operands produce an all-zero result and odd and even parity.

// File: rtl/fshr_pkg.sv
package fshr_pkg;
  // flag vector positions
  localparam int unsigned FL_CF = 3;
  localparam int unsigned FL_SF = 2;
  localparam int unsigned FL_ZF = 1;
  localparam int unsigned FL_PF = 0;
  localparam int unsigned FL_N  = 4;

  typedef logic [FL_N-1:0] flag_vec_t;
endpackage

// File: rtl/fshr_core.sv
module fshr_core #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  input  logic [AMT_W-1:0]  amt,
  input  logic              wide,
  output logic [DATA_W-1:0] res,
  output logic              carry
);
  localparam int unsigned HALF = DATA_W / 2;
  localparam int unsigned CAT  = 2 * DATA_W;

  logic [CAT-1:0] stage [AMT_W+1];
  logic [AMT_W-1:0] amt_m1;

  // concatenated operand: fill source above destination at the active size
  always_comb begin
    if (wide) stage[0] = {src, dst};
    else      stage[0] = {{DATA_W{1'b0}}, src[HALF-1:0], dst[HALF-1:0]};
  end

  // logarithmic right shifter, one stage per amount bit
  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    always_comb begin
      if (amt[k]) stage[k+1] = stage[k] >> (2 ** k);
      else        stage[k+1] = stage[k];
    end
  end

  always_comb begin
    if (wide) res = stage[AMT_W][DATA_W-1:0];
    else      res = {dst[DATA_W-1:HALF], stage[AMT_W][HALF-1:0]};
  end

  // last bit leaving the destination
  assign amt_m1 = amt - 1'b1;
  assign carry  = dst[amt_m1];
endmodule

// File: rtl/fshr_flags.sv
module fshr_flags #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] res,
  input  logic              wide,
  output logic              sign,
  output logic              zero,
  output logic              parity
);
  localparam int unsigned HALF = DATA_W / 2;

  always_comb begin
    sign   = wide ? res[DATA_W-1] : res[HALF-1];
    zero   = wide ? (res == '0) : (res[HALF-1:0] == '0);
    parity = ~^res[7:0];
  end
endmodule

// File: rtl/fshr_unit.sv
module fshr_unit
  import fshr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [FL_N-1:0]   flags_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] res_o,
  output logic [FL_N-1:0]   flags_o,
  output logic [FL_N-1:0]   flags_we_o
);
  localparam int unsigned AMT_W = $clog2(DATA_W);
  localparam int unsigned HALF  = DATA_W / 2;

  logic [AMT_W-1:0]  amt;
  logic              nz;
  logic [DATA_W-1:0] core_res;
  logic              core_cf, f_sf, f_zf, f_pf;
  logic [DATA_W-1:0] res_d;
  flag_vec_t         flags_d, we_d;
  logic              valid_q;
  logic [DATA_W-1:0] res_q;
  flag_vec_t         flags_q, we_q;

  assign amt = cnt_i[AMT_W-1:0];
  assign nz  = |amt;

  fshr_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .dst(dst_i), .src(src_i), .amt(amt), .wide(wide_i),
    .res(core_res), .carry(core_cf)
  );

  fshr_flags #(.DATA_W(DATA_W)) u_flags (
    .res(core_res), .wide(wide_i),
    .sign(f_sf), .zero(f_zf), .parity(f_pf)
  );

  // next-state
  always_comb begin
    res_d   = dst_i;
    flags_d = flags_i;
    we_d    = '0;
    if (nz) begin
      res_d          = core_res;
      flags_d[FL_CF] = core_cf;
      flags_d[FL_SF] = f_sf;
      flags_d[FL_ZF] = f_zf;
      flags_d[FL_PF] = f_pf;
    end
    if (in_valid_i && nz) we_d = '1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      flags_q <= '0;
      we_q    <= '0;
    end else begin
      valid_q <= in_valid_i;
      we_q    <= we_d;
      if (in_valid_i) begin
        res_q   <= res_d;
        flags_q <= flags_d;
      end
    end
  end

  assign out_valid_o = valid_q;
  assign res_o       = res_q;
  assign flags_o     = flags_q;
  assign flags_we_o  = we_q;

  p_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid_o == $past(in_valid_i));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i && (cnt_i[AMT_W-1:0] == '0) |=>
      (res_o == $past(dst_i)) && (flags_o == $past(flags_i)) && (flags_we_o == '0));

  p_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i && !wide_i |=> res_o[DATA_W-1:HALF] == $past(dst_i[DATA_W-1:HALF]));

  p_parity_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && flags_we_o[FL_PF] |-> flags_o[FL_PF] == ~^res_o[7:0]);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> $stable(res_o) && (flags_we_o == '0));
endmodule

// File: tb/sim_fshr_unit.sv
module sim_fshr_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid_i, wide_i;
  logic [31:0] dst_i, src_i;
  logic [7:0]  cnt_i;
  logic [3:0]  flags_i;
  logic        out_valid_o;
  logic [31:0] res_o;
  logic [3:0]  flags_o, flags_we_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  fshr_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .wide_i(wide_i),
    .dst_i(dst_i), .src_i(src_i), .cnt_i(cnt_i), .flags_i(flags_i),
    .out_valid_o(out_valid_o), .res_o(res_o), .flags_o(flags_o),
    .flags_we_o(flags_we_o)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply one operation and check it against the bitwise model
  task automatic run_op(input logic [31:0] d, input logic [31:0] s,
                        input logic [7:0] c, input logic w, input logic [3:0] fi);
    int n, sz;
    logic [31:0] er;
    logic ecf, esf, ezf, epf;
    @(negedge clk);
    in_valid_i = 1'b1; dst_i = d; src_i = s; cnt_i = c; wide_i = w; flags_i = fi;
    @(negedge clk);
    in_valid_i = 1'b0;
    n  = int'(c) % 32;
    sz = w ? 32 : 16;
    chk("R1 valid", {31'b0, out_valid_o}, 32'd1);
    if (n == 0) begin
      chk("R3 result hold", res_o, d);
      chk("R3 flags hold", {28'b0, flags_o}, {28'b0, fi});
      chk("R3 enables", {28'b0, flags_we_o}, 32'd0);
    end else if (n >= sz) begin
      chk("R10 upper pass", {16'b0, res_o[31:16]}, {16'b0, d[31:16]});
      chk("R10 enables", {28'b0, flags_we_o}, 32'hF);
    end else begin
      er = d;
      for (int i = 0; i < sz; i++)
        er[i] = (i < sz - n) ? d[i+n] : s[i+n-sz];
      ecf = d[n-1];
      esf = er[sz-1];
      ezf = w ? (er == 0) : (er[15:0] == 0);
      epf = ~^er[7:0];
      if (w) chk("R4 result32", res_o, er);
      else   chk("R5 result16", res_o, er);
      chk("R6 carry",  {31'b0, flags_o[3]}, {31'b0, ecf});
      chk("R7 sign",   {31'b0, flags_o[2]}, {31'b0, esf});
      chk("R8 zero",   {31'b0, flags_o[1]}, {31'b0, ezf});
      chk("R9 parity", {31'b0, flags_o[0]}, {31'b0, epf});
      chk("R10 enables", {28'b0, flags_we_o}, 32'hF);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid_i = 0; wide_i = 1; dst_i = 0; src_i = 0; cnt_i = 0; flags_i = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'b0, out_valid_o}, 32'd0);
    chk("R1 reset enables", {28'b0, flags_we_o}, 32'd0);
    chk("R1 reset result", res_o, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_sweep(input logic w);
    for (int c = 0; c < 256; c++)
      run_op($urandom, $urandom, c[7:0], w, 4'($urandom));
  endtask

  task automatic t_modulo;
    logic [31:0] r0, r1, d, s;
    d = 32'hC3A5_5A3C; s = 32'h1234_8765;
    for (int w = 0; w < 2; w++) begin
      run_op(d, s, 8'd5, w[0], 4'h0);
      r0 = res_o;
      run_op(d, s, 8'd229, w[0], 4'h0);
      r1 = res_o;
      chk("R2 modulo alias", r1, r0);
    end
  endtask

  task automatic t_corners;
    run_op(32'h0000_0001, 32'h0, 8'd1,  1'b1, 4'h0);  // zero result, carry 1
    run_op(32'h8000_0000, 32'h0, 8'd31, 1'b1, 4'hF);  // top valid amount
    run_op(32'hFFFF_8000, 32'h0, 8'd15, 1'b0, 4'h0);  // 16-bit edge
    run_op(32'h0000_0003, 32'h0000_0001, 8'd1, 1'b1, 4'h0); // sign from source
    run_op(32'h1234_5678, 32'h9ABC_DEF0, 8'd32, 1'b1, 4'h5); // wraps to zero
    run_op(32'hABCD_1234, 32'hFFFF_FFFF, 8'd16, 1'b0, 4'h0); // 16-bit out of range
  endtask

  task automatic t_idle;
    logic [31:0] r;
    run_op(32'h0F0F_F0F0, 32'h5555_AAAA, 8'd7, 1'b1, 4'h0);
    r = res_o;
    @(negedge clk);
    dst_i = 32'hDEAD_BEEF; cnt_i = 8'd3;
    @(negedge clk);
    chk("R11 hold result", res_o, r);
    chk("R11 enables low", {28'b0, flags_we_o}, 32'd0);
    chk("R1 valid low", {31'b0, out_valid_o}, 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sweep(1'b1);
    t_sweep(1'b0);
    t_modulo();
    t_corners();
    t_idle();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule